// File: doc/BRIEF.md
# Memory Read-Modify-Write Combined Operation Sequencer

This block runs one combined memory operation at a time against a single-port byte-wide memory. A start pulse captures an operation code, a target address, the accumulator value and the incoming carry and overflow flags. The block then reads the addressed byte. It writes that byte back unchanged and then writes a modified version of it. Finally it feeds the modified byte into a second arithmetic or logic step on the accumulator.

Each operation pairs one memory modify step with one accumulator step. The modify step is a decrement, an increment, a rotate through carry or a shift. The accumulator step is a compare, a subtract with borrow, an AND, an add with carry, an OR or an XOR. The carry that the modify step produces is the carry that the accumulator step consumes. The enclosing datapath takes the new accumulator and flag values from the output registers once `done_o` pulses. Arithmetic is binary only.

The memory is read combinationally: `mem_rdata_i` must be valid during the read cycle. Results stay on `a_o`, `n_o`, `z_o`, `c_o` and `v_o` until the next operation completes.

Top module: `rmw_seq`

## Requirements
- R1: After reset, `mem_req_o`, `mem_we_o`, `busy_o` and `done_o` are 0, and `a_o`, `n_o`, `z_o`, `c_o` and `v_o` are 0.
- R2: For an accepted start, the memory sees three consecutive request cycles at the captured address. The first is a read (`mem_we_o`=0) in the cycle after the start edge. The second is a write of the byte just read. The third is a write of the modified byte. `done_o` is high for exactly one cycle, the cycle after the last write, and the results hold until the next `done_o`.
- R3: Op code 0 (decrement-compare) writes byte-1. It sets C when A >= byte-1 (unsigned), and sets N and Z from bit 7 and zero-ness of A-(byte-1). A and V are left unchanged.
- R4: Op code 1 (increment-subtract) writes byte+1. A becomes A-(byte+1)-(1-C). C is the inverted borrow, V is the signed overflow of the subtraction, and N and Z come from the new A.
- R5: Op code 2 (rotate-left-AND) writes {byte[6:0],C}. C becomes the old bit 7, A becomes A AND the new byte, and V is unchanged.
- R6: Op code 3 (rotate-right-add) writes {C,byte[7:1]}. It then adds the new byte to A with the old bit 0 as carry in. C is the carry out and V is the signed overflow.
- R7: Op code 4 (shift-left-OR) writes {byte[6:0],0}. C becomes the old bit 7, A becomes A OR the new byte, and V is unchanged.
- R8: Op code 5 (shift-right-XOR) writes {0,byte[7:1]}. C becomes the old bit 0, A becomes A XOR the new byte, and V is unchanged.
- R9: A start pulse arriving while `busy_o` is high, including the `done_o` cycle, is ignored. It causes no extra memory cycle and does not change the running operation's results.
- R10: A start with op code 6 or 7 is ignored. It causes no memory request, no `busy_o` and no `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, sampled only while idle |
| op_i | input | 3 | Operation code (0..5 valid) |
| addr_i | input | 16 | Target byte address |
| a_i | input | 8 | Accumulator value before the operation |
| c_i | input | 1 | Carry flag before the operation |
| v_i | input | 1 | Overflow flag before the operation |
| mem_req_o | output | 1 | Memory cycle request |
| mem_we_o | output | 1 | Memory write enable (1 = write) |
| mem_addr_o | output | 16 | Memory address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, valid in the read cycle |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| a_o | output | 8 | Resulting accumulator |
| n_o | output | 1 | Resulting negative flag |
| z_o | output | 1 | Resulting zero flag |
| c_o | output | 1 | Resulting carry flag |
| v_o | output | 1 | Resulting overflow flag |

## Verification
A new start request can arrive while the sequencer is still driving memory cycles or pulsing `done_o`. The bench provokes this by raising `start_i` with a different op code during the write-back of the original byte, and again in the completion cycle. It judges the outcome by counting read and write cycles and done pulses at the memory port: exactly one read, two writes and one pulse must appear. It also checks that the reported accumulator and flags are those of the first operation.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

  typedef enum logic [2:0] {
    OP_DEC_CMP = 3'd0,
    OP_INC_SUB = 3'd1,
    OP_ROL_AND = 3'd2,
    OP_ROR_ADC = 3'd3,
    OP_SHL_OR  = 3'd4,
    OP_SHR_XOR = 3'd5
  } op_e;

  localparam int unsigned OP_W     = 3;
  localparam int unsigned OP_COUNT = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WB_OLD,
    ST_WB_NEW,
    ST_FIN
  } st_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

endpackage

// File: rtl/rmw_modify.sv
module rmw_modify
  import rmw_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  op_e               op_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              c_i,
  output logic [DATA_W-1:0] data_o,
  output logic              c_o
);

  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  always_comb begin
    data_o = data_i;
    c_o    = c_i;
    unique case (op_i)
      OP_DEC_CMP: data_o = data_i - ONE;
      OP_INC_SUB: data_o = data_i + ONE;
      OP_ROL_AND: begin
        data_o = {data_i[DATA_W-2:0], c_i};
        c_o    = data_i[DATA_W-1];
      end
      OP_ROR_ADC: begin
        data_o = {c_i, data_i[DATA_W-1:1]};
        c_o    = data_i[0];
      end
      OP_SHL_OR: begin
        data_o = {data_i[DATA_W-2:0], 1'b0};
        c_o    = data_i[DATA_W-1];
      end
      OP_SHR_XOR: begin
        data_o = {1'b0, data_i[DATA_W-1:1]};
        c_o    = data_i[0];
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/rmw_alu.sv
module rmw_alu
  import rmw_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  op_e               op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] mem_i,
  input  logic              c_i,
  input  logic              v_i,
  output logic [DATA_W-1:0] acc_o,
  output flags_t            flags_o
);

  localparam int unsigned MSB = DATA_W - 1;

  logic              sub;
  logic              cin;
  logic [DATA_W-1:0] opb;
  logic [DATA_W:0]   sum;
  logic              ovf;

  // compare runs through the same adder with a forced carry-in
  always_comb begin
    sub = (op_i == OP_DEC_CMP) || (op_i == OP_INC_SUB);
    opb = sub ? ~mem_i : mem_i;
    cin = (op_i == OP_DEC_CMP) ? 1'b1 : c_i;
    sum = {1'b0, acc_i} + {1'b0, opb} + {{DATA_W{1'b0}}, cin};
    ovf = (acc_i[MSB] == opb[MSB]) && (sum[MSB] != acc_i[MSB]);
  end

  always_comb begin
    acc_o     = acc_i;
    flags_o.c = c_i;
    flags_o.v = v_i;
    unique case (op_i)
      OP_DEC_CMP: flags_o.c = sum[DATA_W];
      OP_INC_SUB,
      OP_ROR_ADC: begin
        acc_o     = sum[MSB:0];
        flags_o.c = sum[DATA_W];
        flags_o.v = ovf;
      end
      OP_ROL_AND: acc_o = acc_i & mem_i;
      OP_SHL_OR:  acc_o = acc_i | mem_i;
      OP_SHR_XOR: acc_o = acc_i ^ mem_i;
      default: ;
    endcase
    if (op_i == OP_DEC_CMP) begin
      flags_o.n = sum[MSB];
      flags_o.z = (sum[MSB:0] == '0);
    end else begin
      flags_o.n = acc_o[MSB];
      flags_o.z = (acc_o == '0);
    end
  end

endmodule

// File: rtl/rmw_ctrl.sv
module rmw_ctrl
  import rmw_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  output st_e  state_o
);

  st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (go_i) st_d = ST_READ;
      ST_READ:   st_d = ST_WB_OLD;
      ST_WB_OLD: st_d = ST_WB_NEW;
      ST_WB_NEW: st_d = ST_FIN;
      ST_FIN:    st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign state_o = st_q;

endmodule

// File: rtl/rmw_seq.sv
module rmw_seq
  import rmw_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic              c_i,
  input  logic              v_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] a_o,
  output logic              n_o,
  output logic              z_o,
  output logic              c_o,
  output logic              v_o
);

  localparam logic [OP_W-1:0] OP_LIMIT = OP_W'(OP_COUNT);

  st_e               st;
  logic              go;
  op_e               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] acc_q;
  logic              c_q, v_q;
  logic [DATA_W-1:0] rd_q;
  logic [DATA_W-1:0] mod_data;
  logic              mod_c;
  logic [DATA_W-1:0] alu_acc;
  flags_t            alu_flags;
  logic [DATA_W-1:0] res_acc_q;
  flags_t            res_flags_q;

  assign go = start_i && (op_i < OP_LIMIT);

  rmw_ctrl u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (go),
    .state_o(st)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= OP_DEC_CMP;
      addr_q <= '0;
      acc_q  <= '0;
      c_q    <= 1'b0;
      v_q    <= 1'b0;
    end else if (st == ST_IDLE && go) begin
      op_q   <= op_e'(op_i);
      addr_q <= addr_i;
      acc_q  <= a_i;
      c_q    <= c_i;
      v_q    <= v_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              rd_q <= '0;
    else if (st == ST_READ)   rd_q <= mem_rdata_i;
  end

  rmw_modify #(.DATA_W(DATA_W)) u_modify (
    .op_i  (op_q),
    .data_i(rd_q),
    .c_i   (c_q),
    .data_o(mod_data),
    .c_o   (mod_c)
  );

  rmw_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i   (op_q),
    .acc_i  (acc_q),
    .mem_i  (mod_data),
    .c_i    (mod_c),
    .v_i    (v_q),
    .acc_o  (alu_acc),
    .flags_o(alu_flags)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_acc_q   <= '0;
      res_flags_q <= '0;
    end else if (st == ST_WB_NEW) begin
      res_acc_q   <= alu_acc;
      res_flags_q <= alu_flags;
    end
  end

  assign mem_req_o   = (st == ST_READ) || (st == ST_WB_OLD) || (st == ST_WB_NEW);
  assign mem_we_o    = (st == ST_WB_OLD) || (st == ST_WB_NEW);
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = (st == ST_WB_OLD) ? rd_q : mod_data;
  assign busy_o      = (st != ST_IDLE);
  assign done_o      = (st == ST_FIN);
  assign a_o         = res_acc_q;
  assign n_o         = res_flags_q.n;
  assign z_o         = res_flags_q.z;
  assign c_o         = res_flags_q.c;
  assign v_o         = res_flags_q.v;

endmodule

// File: rtl/rmw_seq_chk.sv
module rmw_seq_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic [DATA_W-1:0] mem_rdata_i,
  input logic              busy_o,
  input logic              done_o
);

  a_r2_read_then_wb_old: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |=> (mem_req_o && mem_we_o && mem_wdata_o == $past(mem_rdata_i)));

  a_r2_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> ($past(mem_req_o) && $stable(mem_addr_o)));

  a_r2_done_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(mem_req_o && mem_we_o));

  a_r2_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !mem_req_o);

  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_req_o && !done_o));

endmodule

bind rmw_seq rmw_seq_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .mem_wdata_o(mem_wdata_o),
  .mem_rdata_i(mem_rdata_i),
  .busy_o     (busy_o),
  .done_o     (done_o)
);

// File: tb/tb_rmw_seq.sv
module tb_rmw_seq;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;

  // {op[3], a[8], c, v, byte[8], new_byte[8], exp_a[8], exp_nzcv[4]}
  localparam logic [40:0] VECS [0:NVEC-1] = '{
    {3'd0, 8'h10, 1'b0, 1'b1, 8'h11, 8'h10, 8'h10, 4'b0111},
    {3'd0, 8'h05, 1'b1, 1'b0, 8'h00, 8'hFF, 8'h05, 4'b0000},
    {3'd1, 8'h50, 1'b1, 1'b0, 8'hAF, 8'hB0, 8'hA0, 4'b1001},
    {3'd1, 8'h10, 1'b0, 1'b1, 8'h0F, 8'h10, 8'hFF, 4'b1000},
    {3'd1, 8'h00, 1'b1, 1'b1, 8'hFF, 8'h00, 8'h00, 4'b0110},
    {3'd2, 8'hFF, 1'b1, 1'b1, 8'h81, 8'h03, 8'h03, 4'b0011},
    {3'd2, 8'h0F, 1'b0, 1'b0, 8'h40, 8'h80, 8'h00, 4'b0100},
    {3'd3, 8'h40, 1'b1, 1'b0, 8'h01, 8'h80, 8'hC1, 4'b1000},
    {3'd3, 8'h7F, 1'b0, 1'b0, 8'h03, 8'h01, 8'h81, 4'b1001},
    {3'd3, 8'hFF, 1'b1, 1'b1, 8'h02, 8'h81, 8'h80, 4'b1010},
    {3'd4, 8'h01, 1'b0, 1'b1, 8'hC0, 8'h80, 8'h81, 4'b1011},
    {3'd4, 8'h00, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 4'b0100},
    {3'd5, 8'h55, 1'b0, 1'b0, 8'hAB, 8'h55, 8'h00, 4'b0110},
    {3'd5, 8'h80, 1'b1, 1'b1, 8'h02, 8'h01, 8'h81, 4'b1001}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [15:0] addr_i = '0;
  logic [7:0]  a_i = '0;
  logic        c_i = 1'b0;
  logic        v_i = 1'b0;
  logic        mem_req_o, mem_we_o;
  logic [15:0] mem_addr_o;
  logic [7:0]  mem_wdata_o;
  logic [7:0]  mem_rdata_i;
  logic        busy_o, done_o;
  logic [7:0]  a_o;
  logic        n_o, z_o, c_o, v_o;

  logic [7:0]  rd_byte = '0;
  logic [15:0] exp_addr = '0;
  int          rd_cnt = 0, wr_cnt = 0, done_cnt = 0, busy_cnt = 0, addr_err = 0;
  logic [7:0]  wr_log [0:15];
  int          n_chk = 0, n_bad = 0;

  assign mem_rdata_i = rd_byte;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  rmw_seq dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i),
    .addr_i(addr_i), .a_i(a_i), .c_i(c_i), .v_i(v_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .busy_o(busy_o), .done_o(done_o), .a_o(a_o),
    .n_o(n_o), .z_o(z_o), .c_o(c_o), .v_o(v_o)
  );

  // bus logger, mid-cycle
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (mem_req_o) begin
        if (mem_addr_o != exp_addr) addr_err = addr_err + 1;
        if (!mem_we_o) rd_cnt = rd_cnt + 1;
        else begin
          wr_log[wr_cnt[3:0]] = mem_wdata_o;
          wr_cnt = wr_cnt + 1;
        end
      end
      if (done_o) done_cnt = done_cnt + 1;
      if (busy_o) busy_cnt = busy_cnt + 1;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input logic [2:0] op);
    case (op)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic run_vec(input logic [40:0] v, input logic [15:0] addr);
    int rd0, wr0, dn0, lat;
    string rq;
    rq = req_of(v[40:38]);
    @(negedge clk_i); #1;
    rd0 = rd_cnt; wr0 = wr_cnt; dn0 = done_cnt;
    op_i = v[40:38]; a_i = v[37:30]; c_i = v[29]; v_i = v[28];
    rd_byte = v[27:20]; addr_i = addr; exp_addr = addr;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    lat = 1;
    while (!done_o && lat < 20) begin
      @(negedge clk_i);
      lat++;
    end
    #1;
    check("R2", "done latency", lat, 4);
    check("R2", "reads", rd_cnt - rd0, 1);
    check("R2", "writes", wr_cnt - wr0, 2);
    check("R2", "first write data", int'(wr_log[wr0[3:0]]), int'(v[27:20]));
    check(rq, "new memory byte", int'(wr_log[(wr0 + 1) & 15]), int'(v[19:12]));
    check("R2", "address errors", addr_err, 0);
    check(rq, "accumulator", int'(a_o), int'(v[11:4]));
    check(rq, "nzcv", int'({n_o, z_o, c_o, v_o}), int'(v[3:0]));
    @(negedge clk_i); #1;
    check("R2", "done single pulse", done_cnt - dn0, 1);
    check("R2", "result held", int'(a_o), int'(v[11:4]));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int rd0, wr0, dn0, bz0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1", "req", int'(mem_req_o), 0);
    check("R1", "we", int'(mem_we_o), 0);
    check("R1", "busy/done", int'({busy_o, done_o}), 0);
    check("R1", "acc", int'(a_o), 0);
    check("R1", "nzcv", int'({n_o, z_o, c_o, v_o}), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    for (int i = 0; i < NVEC; i++) run_vec(VECS[i], {i[7:0], 8'h3C} ^ 16'h1200);

    // R9: restart attempts during write-back and during done
    @(negedge clk_i); #1;
    rd0 = rd_cnt; wr0 = wr_cnt; dn0 = done_cnt;
    op_i = 3'd2; a_i = 8'h3C; c_i = 1'b1; v_i = 1'b0; rd_byte = 8'h0F;
    addr_i = 16'hBEEF; exp_addr = 16'hBEEF;
    start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;              // read
    @(negedge clk_i);                               // write original
    op_i = 3'd4; a_i = 8'h00; addr_i = 16'h0001; start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;               // write modified
    @(negedge clk_i);                               // done cycle
    check("R9", "done in expected cycle", int'(done_o), 1);
    start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    repeat (5) @(negedge clk_i);
    #1;
    check("R9", "reads", rd_cnt - rd0, 1);
    check("R9", "writes", wr_cnt - wr0, 2);
    check("R9", "new byte", int'(wr_log[(wr0 + 1) & 15]), 8'h1F);
    check("R9", "done pulses", done_cnt - dn0, 1);
    check("R9", "acc of first op", int'(a_o), 8'h1C);
    check("R9", "nzcv of first op", int'({n_o, z_o, c_o, v_o}), 0);
    check("R9", "address errors", addr_err, 0);

    // R10: unassigned op codes
    for (int k = 6; k < 8; k++) begin
      @(negedge clk_i); #1;
      rd0 = rd_cnt; wr0 = wr_cnt; dn0 = done_cnt; bz0 = busy_cnt;
      op_i = k[2:0]; a_i = 8'hAA; start_i = 1'b1;
      @(negedge clk_i); start_i = 1'b0;
      repeat (6) @(negedge clk_i);
      #1;
      check("R10", "bus cycles", (rd_cnt - rd0) + (wr_cnt - wr0), 0);
      check("R10", "busy cycles", busy_cnt - bz0, 0);
      check("R10", "done pulses", done_cnt - dn0, 0);
      check("R10", "acc unchanged", int'(a_o), 8'h1C);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule